// File: doc/BRIEF.md
# Tuple dispatcher with hot-key steering

This block sits between a wide memory read port and a set of consumer channels in a hardware partitioning pipeline. Every word that the memory side delivers holds several 64-bit tuples side by side. The block stores one word at a time and sends its tuples out one per cycle, starting at lane 0. Each tuple goes to exactly one consumer. Most consumers are partition writers working in parallel. One extra consumer handles a single heavily repeated key. Because of this, the memory side makes one read request per word and not one per tuple.

For each tuple the block compares its key with a hot-key value supplied by the configuration. A match sends the tuple to the skew handler. Any other tuple goes to a partition writer whose index is the low key bits taken modulo the writer count. Every channel uses valid/ready flow control. When the selected consumer is not ready, the block keeps the same tuple on its output. A new word is accepted only in the cycle where the last pending tuple of the current word is taken, or later. This keeps one tuple per cycle across word boundaries. The final word of a stream may be partial: a count field gives how many lanes hold tuples, and the block ignores the other lanes.

Top module: `tuple_dispatch`

## Requirements
- R1: Once reset is released, in_ready is 1 and all channel valids (wr_valid, sk_valid) are 0.
- R2: The tuples of a word appear on out_tuple in lane order 0, 1, ... LANES-1. Lane i sits in in_data bits [64i+63:64i]. Within a tuple the key is in bits [63:32] and the payload in bits [31:0].
- R3: When hot_en is 1 and a tuple's key equals hot_key, only sk_valid is raised for that tuple. When hot_en is 0, the hot key gets no special treatment.
- R4: Every other tuple raises only wr_valid[j], where j = key[HASH_BITS-1:0] mod WRITERS.
- R5: At most one of the channel valids is 1 in any cycle.
- R6: While the selected channel's ready is 0, the next cycle shows the same out_tuple on the same channel. The lane index does not advance.
- R7: in_ready is 1 only when no tuple of the stored word is pending, or when the last pending tuple is taken in that cycle. A stored word is never overwritten.
- R8: For a word accepted with in_last = 1, only lanes 0 to in_count-1 are sent, and in_count values above LANES count as LANES. With in_count = 0 the word is dropped and produces no output. For a word accepted with in_last = 0, all lanes are sent.
- R9: When all readies stay high and words arrive back to back, one tuple is handed off every cycle, including at word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_en | input | 1 | Enables hot-key steering |
| hot_key | input | 32 | Key value routed to the skew handler |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Wide word accepted this cycle |
| in_data | input | LANES*64 | LANES packed tuples, lane 0 in the low bits |
| in_last | input | 1 | Word is the last of the stream; in_count applies |
| in_count | input | $clog2(LANES+1) | Number of lanes in use in a last word |
| out_tuple | output | 64 | Current tuple, shared by all channels |
| wr_valid | output | WRITERS | Per-writer valid |
| wr_ready | input | WRITERS | Per-writer ready |
| sk_valid | output | 1 | Skew handler valid |
| sk_ready | input | 1 | Skew handler ready |

## Verification
A lane index that is wrong shows up at once on out_tuple as a tuple that is missing, repeated or out of order. The bench compares each presented tuple with its expected queue every cycle. A routing fault raises the wrong valid in the same cycle the tuple is presented. A wrong pending count shows up as in_ready rising too early, which would overwrite a stored word, or too late, which leaves a gap at a word boundary. The bench checks in_ready against its model on every offered word, and it also measures the handoff rate over a back-to-back burst.

// File: rtl/tdisp_pkg.sv
package tdisp_pkg;
   localparam int TUPLE_W = 64;
   localparam int KEY_W   = 32;
   localparam int PAY_W   = 32;

   typedef struct packed {
      logic [KEY_W-1:0] key;
      logic [PAY_W-1:0] payload;
   } tuple_t;
endpackage

// File: rtl/tdisp_unpack.sv
module tdisp_unpack
   import tdisp_pkg::*;
#(
   parameter int LANES = 4,
   localparam int CNT_W = $clog2(LANES + 1),
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [LANES*TUPLE_W-1:0]  in_data,
   input  logic                      in_last,
   input  logic [CNT_W-1:0]          in_count,
   output logic                      cur_valid,
   output tuple_t                    cur_tuple,
   input  logic                      cur_take
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(LANES);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   logic [LANES*TUPLE_W-1:0] word_q;
   logic                     full_q;
   logic [CNT_W-1:0]         idx_q;
   logic [CNT_W-1:0]         lim_q;
   logic [CNT_W-1:0]         eff_cnt;
   logic                     last_take;
   logic                     accept;
   tuple_t                   lane_t [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_t[g] = word_q[g*TUPLE_W +: TUPLE_W];
   end

   always_comb begin
      if (!in_last)                eff_cnt = FULL_CNT;
      else if (in_count > FULL_CNT) eff_cnt = FULL_CNT;
      else                          eff_cnt = in_count;
   end

   assign last_take = cur_take && (idx_q == (lim_q - ONE_CNT));
   assign in_ready  = !full_q || last_take;
   assign accept    = in_valid && in_ready;
   assign cur_valid = full_q;
   assign cur_tuple = lane_t[idx_q[IDX_W-1:0]];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
         full_q <= 1'b0;
         idx_q  <= '0;
         lim_q  <= '0;
      end else if (accept) begin
         word_q <= in_data;
         idx_q  <= '0;
         lim_q  <= eff_cnt;
         full_q <= (eff_cnt != '0);
      end else if (cur_take) begin
         idx_q <= idx_q + ONE_CNT;
         if (last_take) full_q <= 1'b0;
      end
   end

   // R7: a stored word stays untouched until its last tuple leaves
   a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !last_take) |=> ($stable(word_q) && $stable(lim_q) && full_q));

   // R8: the lane index never reaches the lane limit while a word is held
   a_r8_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> (idx_q < lim_q));
endmodule

// File: rtl/tdisp_hash.sv
module tdisp_hash #(
   parameter int WRITERS   = 4,
   parameter int HASH_BITS = 8,
   localparam int SEL_W = (WRITERS > 1) ? $clog2(WRITERS) : 1
) (
   input  logic [HASH_BITS-1:0] hkey,
   output logic [SEL_W-1:0]     widx
);
   localparam bit IS_POW2 = ((WRITERS & (WRITERS - 1)) == 0);

   if (IS_POW2) begin : g_pow2
      localparam logic [HASH_BITS-1:0] MASK = HASH_BITS'(WRITERS - 1);
      assign widx = SEL_W'(hkey & MASK);
   end else begin : g_mod
      assign widx = SEL_W'(32'(hkey) % 32'(WRITERS));
   end
endmodule

// File: rtl/tdisp_route.sv
module tdisp_route #(
   parameter int WRITERS = 4,
   localparam int SEL_W = (WRITERS > 1) ? $clog2(WRITERS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cur_valid,
   input  logic               is_hot,
   input  logic [SEL_W-1:0]   widx,
   input  logic [WRITERS-1:0] wr_ready,
   input  logic               sk_ready,
   output logic [WRITERS-1:0] wr_valid,
   output logic               sk_valid,
   output logic               take
);
   assign sk_valid = cur_valid && is_hot;

   for (genvar g = 0; g < WRITERS; g++) begin : g_wr
      assign wr_valid[g] = cur_valid && !is_hot && (widx == SEL_W'(g));
   end

   assign take = (sk_valid && sk_ready) || (|(wr_valid & wr_ready));

   // R4: the hash unit always names an existing writer
   a_r4_writer_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_valid && !is_hot) |-> (32'(widx) < WRITERS));
endmodule

// File: rtl/tuple_dispatch.sv
module tuple_dispatch
   import tdisp_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int WRITERS   = 4,
   parameter int HASH_BITS = 8,
   localparam int CNT_W = $clog2(LANES + 1),
   localparam int SEL_W = (WRITERS > 1) ? $clog2(WRITERS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hot_en,
   input  logic [KEY_W-1:0]         hot_key,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [LANES*TUPLE_W-1:0] in_data,
   input  logic                     in_last,
   input  logic [CNT_W-1:0]         in_count,
   output logic [TUPLE_W-1:0]       out_tuple,
   output logic [WRITERS-1:0]       wr_valid,
   input  logic [WRITERS-1:0]       wr_ready,
   output logic                     sk_valid,
   input  logic                     sk_ready
);
   initial begin
      assert (LANES >= 1) else $error("LANES must be at least 1");
      assert (WRITERS >= 1) else $error("WRITERS must be at least 1");
      assert (HASH_BITS >= SEL_W && HASH_BITS <= KEY_W)
         else $error("HASH_BITS out of range");
   end

   tuple_t           cur_tuple;
   logic             cur_valid;
   logic             take;
   logic             is_hot;
   logic [SEL_W-1:0] widx;

   tdisp_unpack #(.LANES(LANES)) i_unpack (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .in_last   (in_last),
      .in_count  (in_count),
      .cur_valid (cur_valid),
      .cur_tuple (cur_tuple),
      .cur_take  (take)
   );

   tdisp_hash #(.WRITERS(WRITERS), .HASH_BITS(HASH_BITS)) i_hash (
      .hkey (cur_tuple.key[HASH_BITS-1:0]),
      .widx (widx)
   );

   assign is_hot = hot_en && (cur_tuple.key == hot_key);

   tdisp_route #(.WRITERS(WRITERS)) i_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_valid (cur_valid),
      .is_hot    (is_hot),
      .widx      (widx),
      .wr_ready  (wr_ready),
      .sk_ready  (sk_ready),
      .wr_valid  (wr_valid),
      .sk_valid  (sk_valid),
      .take      (take)
   );

   assign out_tuple = cur_tuple;

   // R5: one consumer at most per cycle
   a_r5_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sk_valid, wr_valid}));

   // R6: a refused tuple is presented again unchanged
   a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      ((sk_valid || (|wr_valid)) && !take) |=>
         ($stable(out_tuple) && (sk_valid || (|wr_valid))));
endmodule

// File: tb/test_tuple_dispatch.sv
module test_tuple_dispatch;
   localparam int LANES   = 4;
   localparam int WRITERS = 3;
   localparam int HB      = 8;
   localparam int CW      = $clog2(LANES + 1);

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic               rst_n = 1'b0;
   logic               hot_en = 1'b0;
   logic [31:0]        hot_key = 32'hCAFE_0001;
   logic               in_valid = 1'b0;
   logic               in_ready;
   logic [LANES*64-1:0] in_data = '0;
   logic               in_last = 1'b0;
   logic [CW-1:0]      in_count = '0;
   logic [63:0]        out_tuple;
   logic [WRITERS-1:0] wr_valid;
   logic [WRITERS-1:0] wr_ready = '1;
   logic               sk_valid;
   logic               sk_ready = 1'b1;

   tuple_dispatch #(.LANES(LANES), .WRITERS(WRITERS), .HASH_BITS(HB)) i_tuple_dispatch (
      .clk(clk), .rst_n(rst_n), .hot_en(hot_en), .hot_key(hot_key),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_last(in_last), .in_count(in_count), .out_tuple(out_tuple),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .sk_valid(sk_valid),
      .sk_ready(sk_ready));

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct { logic [63:0] t; int born; } exp_t;
   exp_t q[$];
   int cyc = 0;
   int rmode = 0;
   bit tp_on = 1'b0;
   int tp_first = -1, tp_last = -1, tp_hs = 0;
   bit prev_stall = 1'b0;
   logic [63:0] prev_tuple = '0;

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int dest_of(logic [63:0] t);
      logic [31:0] k = t[63:32];
      if (hot_en && k == hot_key) return WRITERS;
      return int'(k[HB-1:0]) % WRITERS;
   endfunction

   function automatic bit chan_ready(int d);
      if (d == WRITERS) return sk_ready;
      return wr_ready[d];
   endfunction

   // ready pattern generator
   always @(negedge clk) begin
      if (rmode == 0) begin
         wr_ready <= '1;
         sk_ready <= 1'b1;
      end else begin
         wr_ready <= WRITERS'($urandom);
         sk_ready <= 1'($urandom);
      end
   end

   // reference comparison on every cycle
   always @(negedge clk) begin
      #5;
      if (rst_n && !done) begin
         bit any;
         int got, n;
         any = sk_valid || (|wr_valid);
         n = $countones({sk_valid, wr_valid});
         got = sk_valid ? WRITERS : 0;
         for (int i = 0; i < WRITERS; i++) if (wr_valid[i]) got = i;
         if (prev_stall)
            chk(any && out_tuple == prev_tuple, "R6 held tuple", out_tuple, prev_tuple);
         prev_stall = 1'b0;
         if (q.size() > 0 && q[0].born < cyc) begin
            int ed;
            ed = dest_of(q[0].t);
            chk(any, "R2 tuple expected", 64'(n), 64'd1);
            if (any) begin
               chk(n == 1, "R5 single channel", 64'(n), 64'd1);
               chk(out_tuple == q[0].t, "R2 tuple order/content", out_tuple, q[0].t);
               if (ed == WRITERS) chk(got == ed, "R3 hot key to skew", 64'(got), 64'(ed));
               else chk(got == ed, "R4 writer select", 64'(got), 64'(ed));
               if (chan_ready(got)) begin
                  void'(q.pop_front());
                  if (tp_on) begin
                     if (tp_first < 0) tp_first = cyc;
                     tp_last = cyc;
                     tp_hs++;
                  end
               end else begin
                  prev_stall = 1'b1;
                  prev_tuple = out_tuple;
               end
            end
         end else begin
            chk(!any, "R8 no spurious output", 64'(n), 64'd0);
         end
      end
      cyc++;
   end

   task automatic send(logic [LANES*64-1:0] d, bit last, int cnt);
      bit exp_rdy;
      int use_n;
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      in_last  = last;
      in_count = CW'(cnt);
      forever begin
         #1;
         exp_rdy = (q.size() == 0) || (q.size() == 1 && chan_ready(dest_of(q[0].t)));
         chk(in_ready == exp_rdy, "R7 in_ready", 64'(in_ready), 64'(exp_rdy));
         if (in_ready) begin
            use_n = !last ? LANES : (cnt > LANES ? LANES : cnt);
            for (int i = 0; i < use_n; i++) begin
               exp_t e;
               e.t = d[i*64 +: 64];
               e.born = cyc;
               q.push_back(e);
            end
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic idle_in();
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '1;
   endtask

   task automatic drain();
      int guard = 0;
      idle_in();
      while (q.size() > 0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(q.size() == 0, "R2 all tuples delivered", 64'(q.size()), 64'd0);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [LANES*64-1:0] rnd_word();
      logic [LANES*64-1:0] w;
      for (int i = 0; i < LANES*2; i++) w[i*32 +: 32] = $urandom;
      return w;
   endfunction

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [LANES*64-1:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      // R1 reset state
      chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
      chk({sk_valid, wr_valid} == '0, "R1 valids after reset",
          64'({sk_valid, wr_valid}), 64'd0);

      // R2 R4 full words, all ready, hot steering off
      for (int k = 0; k < 4; k++) send(rnd_word(), 1'b0, 0);
      drain();

      // R3 hot key disabled: hot value still goes to a writer
      w = rnd_word();
      w[1*64+32 +: 32] = hot_key;
      send(w, 1'b0, 0);
      drain();

      // R3 hot key enabled; near-miss key shares low bits
      hot_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         w = rnd_word();
         w[1*64+32 +: 32] = hot_key;
         w[3*64+32 +: 32] = hot_key;
         w[2*64+32 +: 32] = hot_key ^ 32'h0100_0000;
         send(w, 1'b0, 0);
      end
      drain();

      // R6 R7 random backpressure
      rmode = 1;
      for (int k = 0; k < 12; k++) begin
         w = rnd_word();
         if (k % 3 == 0) w[0*64+32 +: 32] = hot_key;
         send(w, 1'b0, 0);
      end
      drain();

      // R8 partial last words, including count 0 and an oversize count
      for (int c = 0; c <= LANES + 1 && c < (1 << CW); c++) begin
         send(rnd_word(), 1'b1, c);
         send(rnd_word(), 1'b0, 0);
      end
      drain();
      rmode = 0;
      for (int c = 0; c <= LANES; c++) send(rnd_word(), 1'b1, c);
      drain();

      // R9 back-to-back throughput
      tp_on = 1'b1;
      for (int k = 0; k < 5; k++) send(rnd_word(), 1'b0, 0);
      drain();
      tp_on = 1'b0;
      chk(tp_hs == 5*LANES, "R9 handoff count", 64'(tp_hs), 64'(5*LANES));
      chk(tp_last - tp_first + 1 == 5*LANES, "R9 one tuple per cycle",
          64'(tp_last - tp_first + 1), 64'(5*LANES));

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule